// File: doc/BRIEF.md
# Serial Command Register File

This block receives control commands over an asynchronous serial line and holds the settings that steer a tone-generation and predistortion signal chain. A receiver recovers bytes in 8N1 format. A small framer then groups the bytes into commands. Each command is one address byte followed by a 32-bit data word. The framer writes the word into one of nine fixed registers.

The register outputs feed the rest of the system directly. They are:
- enables for the predistorter, the modulator oscillator and the demodulator oscillator;
- a predistorter clear and a system clear;
- the select that chooses the converter's source;
- frequency and amplitude words for the baseband and RF tones;
- three alignment delays;
- a loop gain.

Each accepted write raises a one-cycle strobe that carries the register's address, so downstream logic can react to a setting change.

Top module: `ctrl_uart_regs`

## Requirements
- R1: After reset every register output is zero, except `bb_gain` and `rf_gain`, which hold half scale (only bit GAIN_W-1 set). `wr_stb` is low.
- R2: Serial bytes use 8N1 format with the least significant bit first. One bit lasts OSR*TICK_DIV clock cycles. Each bit is sampled at its middle.
- R3: A low pulse on `rxd` that has ended before half a bit time has passed is not taken as a start bit and produces no byte.
- R4: A command is an address byte followed by four data bytes, most significant first. No register changes before the fourth data byte has been received.
- R5: Address 0x00 writes the control bits from the low bits of the word:
  - bit 0 is `dac_sel` (0 selects the predistorter output, 1 selects the tone);
  - bit 1 is `pd_en`;
  - bit 2 is `pd_clr`;
  - bit 3 is `mod_osc_en`;
  - bit 4 is `demod_osc_en`;
  - bit 5 is `sys_clr`.
- R6: Addresses 0x01 to 0x04 write `bb_freq`, `bb_gain`, `rf_freq` and `rf_gain`. Each register takes the low bits of the word that match its width.
- R7: Addresses 0x05, 0x06 and 0x07 write `dly_in`, `dly_des` and `dly_demod` (low DLY_W bits). Address 0x08 writes `loop_gain` (low LGAIN_W bits).
- R8: A command to an address of 0x09 or above changes no register and raises no strobe.
- R9: A byte whose stop bit is low discards the command in progress. The receiver then waits for the line to return high, and the next byte is taken as an address.
- R10: Each write to a defined address raises `wr_stb` for exactly one cycle. That cycle is the one in which the new value first appears on the outputs, and `wr_addr` holds the register's address during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line, idle high |
| dac_sel | output | 1 | Converter source select |
| pd_en | output | 1 | Predistorter enable |
| pd_clr | output | 1 | Predistorter clear |
| mod_osc_en | output | 1 | Modulator oscillator enable |
| demod_osc_en | output | 1 | Demodulator oscillator enable |
| sys_clr | output | 1 | System clear |
| bb_freq | output | FREQ_W | Baseband tone frequency word |
| bb_gain | output | GAIN_W | Baseband tone amplitude |
| rf_freq | output | FREQ_W | RF oscillator frequency word |
| rf_gain | output | GAIN_W | RF oscillator amplitude |
| dly_in | output | DLY_W | Input-signal alignment delay |
| dly_des | output | DLY_W | Desired-signal alignment delay |
| dly_demod | output | DLY_W | Modulator-to-demodulator phase delay |
| loop_gain | output | LGAIN_W | Predistorter loop gain |
| wr_stb | output | 1 | One-cycle pulse on each register update |
| wr_addr | output | 8 | Address of the register last updated |

## Verification
The assertions assume that complete commands on `rxd` are spaced at least one full byte time apart, which in any case follows from the five-byte framing. Under that assumption two strobes can never fall on adjacent cycles, and a register can only move in a cycle that carries its own strobe. The stimulus respects this by driving only whole, correctly timed frames with idle gaps between bytes. There are two deliberate exceptions: a short glitch, which ends well before the mid-start sample, and one stop bit held low, after which the line is released high before the next frame.

// File: rtl/ctrl_uart_regs.sv
module ctrl_uart_regs #(
  parameter int TICK_DIV = 2,
  parameter int OSR      = 16,
  parameter int FREQ_W   = 32,
  parameter int GAIN_W   = 16,
  parameter int DLY_W    = 10,
  parameter int LGAIN_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxd,
  output logic               dac_sel,
  output logic               pd_en,
  output logic               pd_clr,
  output logic               mod_osc_en,
  output logic               demod_osc_en,
  output logic               sys_clr,
  output logic [FREQ_W-1:0]  bb_freq,
  output logic [GAIN_W-1:0]  bb_gain,
  output logic [FREQ_W-1:0]  rf_freq,
  output logic [GAIN_W-1:0]  rf_gain,
  output logic [DLY_W-1:0]   dly_in,
  output logic [DLY_W-1:0]   dly_des,
  output logic [DLY_W-1:0]   dly_demod,
  output logic [LGAIN_W-1:0] loop_gain,
  output logic               wr_stb,
  output logic [7:0]         wr_addr
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam int OSR_W = $clog2(OSR + 1);
  localparam int HALF  = OSR / 2;
  localparam logic [GAIN_W-1:0] GAIN_MID = {1'b1, {(GAIN_W-1){1'b0}}};
  localparam logic [7:0] NREG = 8'd9;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} rx_st_t;

  logic [1:0]       rx_q;
  logic             rx_s;
  rx_st_t           st;
  logic [DIV_W-1:0] div_cnt;
  logic [OSR_W-1:0] sub_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic             byte_ok, frm_err, tick;

  logic [2:0]  idx;
  logic [7:0]  addr_q;
  logic [23:0] data_q;
  logic [31:0] word;
  logic        commit;

  assign rx_s   = rx_q[1];
  assign tick   = (st != S_IDLE) && (st != S_HOLD) && (div_cnt == DIV_W'(TICK_DIV - 1));
  assign word   = {data_q, shreg};
  assign commit = byte_ok && (idx == 3'd4);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_q <= 2'b11;
    else        rx_q <= {rx_q[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div_cnt <= '0; sub_cnt <= '0; bit_cnt <= '0;
      shreg <= '0; byte_ok <= 1'b0; frm_err <= 1'b0;
    end else begin
      byte_ok <= 1'b0;
      frm_err <= 1'b0;
      if (st == S_IDLE || st == S_HOLD || tick) div_cnt <= '0;
      else                                      div_cnt <= div_cnt + 1'b1;
      if (tick) sub_cnt <= sub_cnt + 1'b1;
      case (st)
        S_IDLE: begin
          sub_cnt <= '0;
          if (!rx_s) st <= S_START;
        end
        S_START:
          if (tick && sub_cnt == OSR_W'(HALF - 1)) begin
            sub_cnt <= '0;
            bit_cnt <= '0;
            st      <= rx_s ? S_IDLE : S_DATA;
          end
        S_DATA:
          if (tick && sub_cnt == OSR_W'(OSR - 1)) begin
            sub_cnt <= '0;
            shreg   <= {rx_s, shreg[7:1]};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) st <= S_STOP;
          end
        S_STOP:
          if (tick && sub_cnt == OSR_W'(OSR - 1)) begin
            sub_cnt <= '0;
            if (rx_s) begin byte_ok <= 1'b1; st <= S_IDLE; end
            else      begin frm_err <= 1'b1; st <= S_HOLD; end
          end
        S_HOLD:
          if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; addr_q <= '0; data_q <= '0;
    end else if (frm_err) begin
      idx <= '0;
    end else if (byte_ok) begin
      if (idx == 3'd0) addr_q <= shreg;
      else             data_q <= {data_q[15:0], shreg};
      idx <= (idx == 3'd4) ? 3'd0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sys_clr, demod_osc_en, mod_osc_en, pd_clr, pd_en, dac_sel} <= '0;
      bb_freq <= '0; bb_gain <= GAIN_MID; rf_freq <= '0; rf_gain <= GAIN_MID;
      dly_in <= '0; dly_des <= '0; dly_demod <= '0; loop_gain <= '0;
      wr_stb <= 1'b0; wr_addr <= '0;
    end else begin
      wr_stb <= commit && (addr_q < NREG);
      if (commit && addr_q < NREG) wr_addr <= addr_q;
      if (commit)
        case (addr_q)
          8'h00: {sys_clr, demod_osc_en, mod_osc_en, pd_clr, pd_en, dac_sel} <= word[5:0];
          8'h01: bb_freq   <= word[FREQ_W-1:0];
          8'h02: bb_gain   <= word[GAIN_W-1:0];
          8'h03: rf_freq   <= word[FREQ_W-1:0];
          8'h04: rf_gain   <= word[GAIN_W-1:0];
          8'h05: dly_in    <= word[DLY_W-1:0];
          8'h06: dly_des   <= word[DLY_W-1:0];
          8'h07: dly_demod <= word[DLY_W-1:0];
          8'h08: loop_gain <= word[LGAIN_W-1:0];
          default: ;
        endcase
    end
  end
endmodule

module ctrl_uart_regs_chk #(
  parameter int FREQ_W  = 32,
  parameter int GAIN_W  = 16,
  parameter int DLY_W   = 10,
  parameter int LGAIN_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dac_sel, pd_en, pd_clr, mod_osc_en, demod_osc_en, sys_clr,
  input logic [FREQ_W-1:0]  bb_freq, rf_freq,
  input logic [GAIN_W-1:0]  bb_gain, rf_gain,
  input logic [DLY_W-1:0]   dly_in, dly_des, dly_demod,
  input logic [LGAIN_W-1:0] loop_gain,
  input logic               wr_stb,
  input logic [7:0]         wr_addr
);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r8_defined_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_addr < 8'd9);

  a_r4_no_silent_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable({bb_freq, rf_freq, bb_gain, rf_gain, dly_in, dly_des, dly_demod, loop_gain,
                         dac_sel, pd_en, pd_clr, mod_osc_en, demod_osc_en, sys_clr}));

  a_r5_ctrl_only_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr != 8'h00) |-> $stable({dac_sel, pd_en, pd_clr, mod_osc_en, demod_osc_en, sys_clr}));

  a_r6_tone_only_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr != 8'h01) |-> $stable(bb_freq));

  a_r7_gain_only_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr != 8'h08) |-> $stable(loop_gain));
endmodule

bind ctrl_uart_regs ctrl_uart_regs_chk #(
  .FREQ_W(FREQ_W), .GAIN_W(GAIN_W), .DLY_W(DLY_W), .LGAIN_W(LGAIN_W)
) u_chk (.*);

// File: tb/ctrl_uart_regs_test.sv
module ctrl_uart_regs_test;
  localparam int BIT = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic dac_sel, pd_en, pd_clr, mod_osc_en, demod_osc_en, sys_clr;
  logic [31:0] bb_freq, rf_freq;
  logic [15:0] bb_gain, rf_gain, loop_gain;
  logic [9:0]  dly_in, dly_des, dly_demod;
  logic        wr_stb;
  logic [7:0]  wr_addr;

  ctrl_uart_regs uut (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, strobes = 0;
  logic [7:0] last_addr = 8'hFF;
  logic prev_stb = 1'b0;
  bit done = 1'b0;

  logic [5:0]  e_ctrl;
  logic [31:0] e_bbf, e_rff;
  logic [15:0] e_bbg, e_rfg, e_lg;
  logic [9:0]  e_di, e_dd, e_dm;
  int e_strobes = 0;

  always @(negedge clk) begin
    if (wr_stb) begin
      strobes++;
      last_addr = wr_addr;
      if (prev_stb) begin
        fails++;
        $display("FAIL R10 strobe wider than one cycle: got 1 expected 0");
      end
    end
    prev_stb = wr_stb;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({sys_clr, demod_osc_en, mod_osc_en, pd_clr, pd_en, dac_sel} == e_ctrl, {"R5 ctrl ", tag},
          64'({sys_clr, demod_osc_en, mod_osc_en, pd_clr, pd_en, dac_sel}), 64'(e_ctrl));
    check({bb_freq, bb_gain} == {e_bbf, e_bbg}, {"R6 bb ", tag}, {16'h0, bb_freq, bb_gain}, {16'h0, e_bbf, e_bbg});
    check({rf_freq, rf_gain} == {e_rff, e_rfg}, {"R6 rf ", tag}, {16'h0, rf_freq, rf_gain}, {16'h0, e_rff, e_rfg});
    check({dly_in, dly_des, dly_demod, loop_gain} == {e_di, e_dd, e_dm, e_lg}, {"R7 dly/gain ", tag},
          64'({dly_in, dly_des, dly_demod, loop_gain}), 64'({e_di, e_dd, e_dm, e_lg}));
    check(strobes == e_strobes, {"R10 strobe count ", tag}, 64'(strobes), 64'(e_strobes));
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    @(negedge clk) rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic model(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: e_ctrl = d[5:0];
      8'h01: e_bbf = d;
      8'h02: e_bbg = d[15:0];
      8'h03: e_rff = d;
      8'h04: e_rfg = d[15:0];
      8'h05: e_di = d[9:0];
      8'h06: e_dd = d[9:0];
      8'h07: e_dm = d[9:0];
      8'h08: e_lg = d[15:0];
      default: ;
    endcase
    if (a < 8'd9) e_strobes++;
  endtask

  task automatic send_cmd(input logic [7:0] a, input logic [31:0] d, input bit mid_check);
    send_byte(a, 1'b1);
    send_byte(d[31:24], 1'b1);
    send_byte(d[23:16], 1'b1);
    send_byte(d[15:8], 1'b1);
    if (mid_check) check_all("R4 before last data byte");
    send_byte(d[7:0], 1'b1);
    model(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    e_ctrl = '0; e_bbf = '0; e_rff = '0; e_bbg = 16'h8000; e_rfg = 16'h8000;
    e_di = '0; e_dd = '0; e_dm = '0; e_lg = '0;
    repeat (5) @(negedge clk);
    check_all("R1 reset state");
    check(wr_stb == 1'b0, "R1 strobe low in reset", 64'(wr_stb), 64'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_all("R1 after reset release");

    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 16; a++) begin
        logic [31:0] d;
        d = (p == 0) ? (32'hA5C3_7E19 ^ {4{8'(a)}}) : (32'h5A3C_81E6 + 32'(a * 7));
        send_cmd(8'(a), d, p == 0);
        check_all(a < 9 ? "R2 write" : "R8 undefined address");
        if (a < 9) check(last_addr == 8'(a), "R10 strobe address", 64'(last_addr), 64'(a));
      end
    end

    send_cmd(8'h01, 32'h0102_0408, 1'b0);
    check(bb_freq == 32'h0102_0408, "R2 bit order", 64'(bb_freq), 64'h0102_0408);
    send_cmd(8'h00, 32'h0000_002B, 1'b0);
    check({sys_clr, pd_en, dac_sel} == 3'b111 && {demod_osc_en, pd_clr} == 2'b00 && mod_osc_en,
          "R5 bit map", 64'({sys_clr, demod_osc_en, mod_osc_en, pd_clr, pd_en, dac_sel}), 64'h2B);

    @(negedge clk) rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT * 12) @(negedge clk);
    check_all("R3 glitch ignored");
    send_cmd(8'h06, 32'h0000_0155, 1'b0);
    check_all("R3 frame after glitch");

    send_byte(8'h03, 1'b1);
    send_byte(8'h11, 1'b1);
    send_byte(8'h22, 1'b1);
    @(negedge clk) rxd = 1'b0;
    repeat (BIT * 11 + 40) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
    check_all("R9 aborted frame");
    send_cmd(8'h05, 32'h0000_03C1, 1'b0);
    check_all("R9 resync on address byte");
    check(rf_freq == e_rff, "R9 rf_freq untouched", 64'(rf_freq), 64'(e_rff));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule